// File: doc/BRIEF.md
# Status and Control Flags Unit

This unit keeps the 16-bit flags word of a small 16-bit processor and computes the six arithmetic status flags for each ALU operation. The ALU supplies two operands, a carry-in, an operation class (add, subtract or logic) and a size select (byte or word). The unit then derives carry, overflow, zero, sign, parity and half-carry. For add and subtract it forms the sum itself, so that it can see the carries. For a logic operation the ALU presents its finished result on operand A.

The word also holds three control flags: string direction, interrupt enable and single step. Their levels leave the block on dedicated outputs. Software can load the whole word and read it back. The carry, direction and interrupt-enable flags can each be set or cleared by a one-cycle command.

The block has no state machine. Its only state is the flags register, which is updated on the rising clock edge according to a fixed priority.

Top module: `flags_unit`

## Requirements
- R1: With reset held low (asynchronous, active low), the flags word and the three control outputs read zero.
- R2: On an update, CF is the carry out of the top bit of the selected size for add, and the borrow for subtract. For subtract the result is A minus B minus the carry-in. OF is the signed overflow at the selected size. Byte size (`wide_i`=0) uses bits 7:0 only; word size uses bits 15:0.
- R3: On an update, ZF (bit 6) is 1 when the result at the selected size is zero. SF (bit 7) is result bit 7 in byte size and result bit 15 in word size.
- R4: On an update, PF (bit 2) is 1 when bits 7:0 of the result hold an even number of ones, whatever the size.
- R5: AF (bit 4) is the carry (add) or borrow (subtract) out of bit 3. For a logic operation (`op_i[1]`=1), CF (bit 0) and OF (bit 11) become 0, AF keeps its value, and operand A is taken as the result. Operation codes: 00 add, 01 subtract, 1x logic.
- R6: With `upd_i`, `wr_i` and all set/clear commands low, the flags word does not change.
- R7: A load (`wr_i`) writes bits 0, 2, 4, 6, 7, 8, 9, 10 and 11 from `wr_data_i`. It takes priority over `upd_i` in the same cycle. The other bits always read zero.
- R8: The set and clear commands for CF (bit 0), IF (bit 9) and DF (bit 10) take priority over both a load and an update in the same cycle. When set and clear arrive together, set wins.
- R9: `dir_o`, `int_en_o` and `step_o` follow bits 10, 9 and 8. An ALU update leaves bits 8 to 10 unchanged.
- R10: Every change appears on `flags_o` after the rising edge at which it is sampled, and never before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 16 | Operand A (the result, for logic operations) |
| opb_i | input | 16 | Operand B |
| cin_i | input | 1 | Carry-in (borrow-in for subtract) |
| op_i | input | 2 | Operation class: 00 add, 01 subtract, 1x logic |
| wide_i | input | 1 | 1 word size, 0 byte size |
| upd_i | input | 1 | Apply the computed status flags |
| wr_i | input | 1 | Load the whole word |
| wr_data_i | input | 16 | Word to load |
| cf_set_i | input | 1 | Set carry |
| cf_clr_i | input | 1 | Clear carry |
| df_set_i | input | 1 | Set direction |
| df_clr_i | input | 1 | Clear direction |
| if_set_i | input | 1 | Set interrupt enable |
| if_clr_i | input | 1 | Clear interrupt enable |
| flags_o | output | 16 | Flags word |
| dir_o | output | 1 | Direction flag level |
| int_en_o | output | 1 | Interrupt-enable level |
| step_o | output | 1 | Single-step level |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. The bench changes inputs on the falling edge and reads `flags_o` on the next falling edge, just after the edge that captured them. One check reads the word right after a new stimulus is applied and before the edge, to show that nothing leaks through combinationally. Reset is asynchronous, so its check reads the word a short delay after `rst_n` falls, without waiting for a clock.

// File: rtl/flags_pkg.sv
package flags_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam int CF_BIT = 0;
    localparam int PF_BIT = 2;
    localparam int AF_BIT = 4;
    localparam int ZF_BIT = 6;
    localparam int SF_BIT = 7;
    localparam int TF_BIT = 8;
    localparam int IF_BIT = 9;
    localparam int DF_BIT = 10;
    localparam int OF_BIT = 11;
    localparam int NFLAGS = 9;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_LOGIC = 2'b10
    } op_cls_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic af_we;
        logic zf;
        logic sf;
        logic of;
    } status_t;

    typedef int pos_list_t [NFLAGS];
    localparam pos_list_t FLAG_POS = '{CF_BIT, PF_BIT, AF_BIT, ZF_BIT, SF_BIT,
                                       TF_BIT, IF_BIT, DF_BIT, OF_BIT};

    function automatic logic [DATA_W-1:0] defined_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NFLAGS; i++) m[FLAG_POS[i]] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/flag_gen.sv
module flag_gen
    import flags_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int H = BYTE_W,
    parameter int N = NIB_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [1:0]   op_i,
    input  logic         wide_i,
    output status_t      st_o
);
    logic          is_logic, is_sub, cx;
    logic [W-1:0]  bx, res;
    logic [W:0]    full_sum;
    logic [H:0]    byte_sum;
    logic [N:0]    nib_sum;
    logic          carry, sa, sb, sr, zero;

    assign is_logic = op_i[1];
    assign is_sub   = (op_i == OP_SUB);
    assign bx       = is_sub ? ~b_i : b_i;
    assign cx       = is_sub ? ~cin_i : cin_i;

    assign full_sum = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cx};
    assign byte_sum = {1'b0, a_i[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, cx};
    assign nib_sum  = {1'b0, a_i[N-1:0]} + {1'b0, bx[N-1:0]} + {{N{1'b0}}, cx};

    assign res = is_logic ? a_i : full_sum[W-1:0];

    generate
        if (W > H) begin : g_sized
            assign carry = wide_i ? full_sum[W] : byte_sum[H];
            assign sa    = wide_i ? a_i[W-1] : a_i[H-1];
            assign sb    = wide_i ? bx[W-1]  : bx[H-1];
            assign sr    = wide_i ? res[W-1] : res[H-1];
            assign zero  = wide_i ? (res == '0) : (res[H-1:0] == '0);
        end else begin : g_flat
            assign carry = full_sum[W];
            assign sa    = a_i[W-1];
            assign sb    = bx[W-1];
            assign sr    = res[W-1];
            assign zero  = (res == '0);
        end
    endgenerate

    always_comb begin
        st_o.cf    = is_logic ? 1'b0 : (carry ^ is_sub);
        st_o.of    = is_logic ? 1'b0 : ((sa == sb) && (sr != sa));
        st_o.af    = nib_sum[N] ^ is_sub;
        st_o.af_we = ~is_logic;
        st_o.zf    = zero;
        st_o.sf    = sr;
        st_o.pf    = ~(^res[H-1:0]);
    end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import flags_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  status_t      st_i,
    input  logic         upd_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         cf_set_i,
    input  logic         cf_clr_i,
    input  logic         df_set_i,
    input  logic         df_clr_i,
    input  logic         if_set_i,
    input  logic         if_clr_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] MASK = defined_mask();

    logic [W-1:0] q, nxt;

    always_comb begin
        nxt = q;
        if (wr_i) begin
            nxt = wr_data_i & MASK;
        end else if (upd_i) begin
            nxt[CF_BIT] = st_i.cf;
            nxt[PF_BIT] = st_i.pf;
            nxt[ZF_BIT] = st_i.zf;
            nxt[SF_BIT] = st_i.sf;
            nxt[OF_BIT] = st_i.of;
            if (st_i.af_we) nxt[AF_BIT] = st_i.af;
        end
        if (cf_clr_i) nxt[CF_BIT] = 1'b0;
        if (cf_set_i) nxt[CF_BIT] = 1'b1;
        if (df_clr_i) nxt[DF_BIT] = 1'b0;
        if (df_set_i) nxt[DF_BIT] = 1'b1;
        if (if_clr_i) nxt[IF_BIT] = 1'b0;
        if (if_set_i) nxt[IF_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign q_o = q;
endmodule

// File: rtl/flags_unit.sv
module flags_unit
    import flags_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         cin_i,
    input  logic [1:0]   op_i,
    input  logic         wide_i,
    input  logic         upd_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         cf_set_i,
    input  logic         cf_clr_i,
    input  logic         df_set_i,
    input  logic         df_clr_i,
    input  logic         if_set_i,
    input  logic         if_clr_i,
    output logic [W-1:0] flags_o,
    output logic         dir_o,
    output logic         int_en_o,
    output logic         step_o
);
    status_t st;

    flag_gen #(.W(W)) u_gen (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (cin_i),
        .op_i   (op_i),
        .wide_i (wide_i),
        .st_o   (st)
    );

    flag_reg #(.W(W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_i      (st),
        .upd_i     (upd_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .cf_set_i  (cf_set_i),
        .cf_clr_i  (cf_clr_i),
        .df_set_i  (df_set_i),
        .df_clr_i  (df_clr_i),
        .if_set_i  (if_set_i),
        .if_clr_i  (if_clr_i),
        .q_o       (flags_o)
    );

    assign dir_o    = flags_o[DF_BIT];
    assign int_en_o = flags_o[IF_BIT];
    assign step_o   = flags_o[TF_BIT];
endmodule

// File: rtl/flags_unit_chk.sv
module flags_unit_chk
    import flags_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   op_i,
    input logic         upd_i,
    input logic         wr_i,
    input logic         cf_set_i,
    input logic         cf_clr_i,
    input logic         df_set_i,
    input logic         df_clr_i,
    input logic         if_set_i,
    input logic         if_clr_i,
    input logic [W-1:0] flags_o
);
    localparam logic [W-1:0] MASK = defined_mask();
    logic any_cmd;
    assign any_cmd = cf_set_i | cf_clr_i | df_set_i | df_clr_i | if_set_i | if_clr_i;

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~MASK) == '0);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !wr_i && !any_cmd) |=> $stable(flags_o));

    assert_cf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cf_set_i |=> flags_o[CF_BIT]);

    assert_cf_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_clr_i && !cf_set_i) |=> !flags_o[CF_BIT]);

    assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_i && op_i[1] && !cf_set_i) |=> (!flags_o[CF_BIT] && !flags_o[OF_BIT]));

    assert_logic_keeps_af_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_i && op_i[1]) |=> $stable(flags_o[AF_BIT]));

    assert_ctl_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_i && !any_cmd) |=> $stable(flags_o[DF_BIT:TF_BIT]));
endmodule

bind flags_unit flags_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .upd_i    (upd_i),
    .wr_i     (wr_i),
    .cf_set_i (cf_set_i),
    .cf_clr_i (cf_clr_i),
    .df_set_i (df_set_i),
    .df_clr_i (df_clr_i),
    .if_set_i (if_set_i),
    .if_clr_i (if_clr_i),
    .flags_o  (flags_o)
);

// File: tb/tb_flags_unit.sv
module tb_flags_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // {op[2], wide, cin, a[16], b[16], expected[16]}
    localparam logic [51:0] VEC [NV] = '{
        {2'b00, 1'b1, 1'b0, 16'h0001, 16'h0001, 16'h0000},
        {2'b00, 1'b1, 1'b0, 16'h7FFF, 16'h0001, 16'h0894},
        {2'b00, 1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'h0055},
        {2'b00, 1'b0, 1'b0, 16'h127F, 16'h0001, 16'h0890},
        {2'b01, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'h0095},
        {2'b01, 1'b1, 1'b0, 16'h8000, 16'h0001, 16'h0814},
        {2'b01, 1'b0, 1'b1, 16'h0005, 16'h0004, 16'h0044},
        {2'b00, 1'b1, 1'b1, 16'h0008, 16'h0007, 16'h0010},
        {2'b10, 1'b1, 1'b0, 16'h8003, 16'hFFFF, 16'h0094},
        {2'b10, 1'b0, 1'b0, 16'hFF00, 16'h0000, 16'h0054},
        {2'b01, 1'b1, 1'b0, 16'h1234, 16'h1234, 16'h0044},
        {2'b11, 1'b1, 1'b0, 16'h0100, 16'h0000, 16'h0004}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0, opb = '0, wr_data = '0;
    logic        cin = 1'b0, wide = 1'b0, upd = 1'b0, wr = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        cf_set = 0, cf_clr = 0, df_set = 0, df_clr = 0, if_set = 0, if_clr = 0;
    logic [15:0] flags;
    logic        dir, int_en, step;
    int          total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flags_unit dut (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .cin_i(cin),
        .op_i(op), .wide_i(wide), .upd_i(upd), .wr_i(wr), .wr_data_i(wr_data),
        .cf_set_i(cf_set), .cf_clr_i(cf_clr), .df_set_i(df_set), .df_clr_i(df_clr),
        .if_set_i(if_set), .if_clr_i(if_clr), .flags_o(flags),
        .dir_o(dir), .int_en_o(int_en), .step_o(step)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        upd = 0; wr = 0; cf_set = 0; cf_clr = 0;
        df_set = 0; df_clr = 0; if_set = 0; if_clr = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic alu(input logic [1:0] o, input logic w, input logic c,
                       input logic [15:0] a, input logic [15:0] b);
        op = o; wide = w; cin = c; opa = a; opb = b; upd = 1;
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        check("R1 reset word", flags, 16'h0000);
        check("R1 reset ctl", {13'd0, dir, int_en, step}, 16'h0000);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R4 R5: vector table
        for (int i = 0; i < NV; i++) begin
            alu(VEC[i][51:50], VEC[i][49], VEC[i][48], VEC[i][47:32], VEC[i][31:16]);
            tick();
            check($sformatf("R2/R3/R4/R5 vector %0d", i), flags, VEC[i][15:0]);
        end

        // R6: no enable, no change
        alu(2'b00, 1'b1, 1'b0, 16'hFFFF, 16'h0001);
        upd = 0;
        tick();
        check("R6 hold", flags, 16'h0004);

        // R7: load keeps only defined bits
        wr = 1; wr_data = 16'hFFFF;
        tick();
        check("R7 load mask", flags, 16'h0FD5);
        check("R9 ctl outputs", {13'd0, dir, int_en, step}, 16'h0007);

        // R10: nothing visible before the edge; R9: update keeps control bits
        alu(2'b00, 1'b1, 1'b0, 16'h0001, 16'h0001);
        #1;
        check("R10 no early change", flags, 16'h0FD5);
        tick();
        check("R9 update keeps ctl", flags, 16'h0700);

        // R7: load beats update
        alu(2'b00, 1'b1, 1'b0, 16'hFFFF, 16'h0001);
        wr = 1; wr_data = 16'h0000;
        tick();
        check("R7 load over update", flags, 16'h0000);

        // R8: cf_set over update, df_set
        alu(2'b00, 1'b1, 1'b0, 16'h0001, 16'h0001);
        cf_set = 1; df_set = 1;
        tick();
        check("R8 set over update", flags, 16'h0401);
        check("R9 dir level", {15'd0, dir}, 16'h0001);

        // R8: set beats clear, df_clr
        if_set = 1; if_clr = 1; df_clr = 1;
        tick();
        check("R8 set wins clear", flags, 16'h0201);
        check("R9 int_en level", {14'd0, dir, int_en}, 16'h0001);

        // R8: cf_clr over load
        wr = 1; wr_data = 16'h0FD5; cf_clr = 1;
        tick();
        check("R8 clear over load", flags, 16'h0FD4);

        // R1: asynchronous reset mid-run
        #2;
        rst_n = 0;
        #1;
        check("R1 async reset", flags, 16'h0000);
        check("R1 async reset ctl", {13'd0, dir, int_en, step}, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule